// File: doc/BRIEF.md
# Sound Unit Register Bank with Master Power Gating

This block is the processor-side register file of a four-channel sound unit. It stores the control registers of two pulse channels, a wave channel and a noise channel, plus a master volume register, a channel routing register, a master power/status byte and a 16-byte waveform store. Each register reads back with its own fixed set of always-one bits. A single write into a register produces a one-cycle strobe, together with the value, for the channel logic that sits downstream.

A two-state power machine gates the bank. In `PWR_ON`, channel and mixer writes are stored. A status write with bit 7 clear takes the `POWER_DOWN` transition to `PWR_OFF`. On that same clock edge every channel and mixer register becomes zero. While the machine is in `PWR_OFF`, writes to those registers are dropped. The exception is the legacy build (`LEGACY_MODEL = 1`): it still accepts the wave and noise length registers, and it still forwards the length part of the pulse duty/length registers to the channels. A status write with bit 7 set takes the `POWER_UP` transition back to `PWR_ON`.

While the wave channel plays, waveform accesses follow the playback byte instead of the address on the bus. On the legacy build this holds only inside the channel's access window.

Top module: `snd_reg_bank`

## Requirements
- R1: After reset, the power/status byte reads `{1, 3'b111, ch_active}`, which is 0xF1 when ch_active is 4'b0001. Master volume (index 18) reads 0x77 and routing (index 19) reads 0xF3. All other channel registers hold 0 and read back their mask.
- R2: Register index i (0..19) reads back as stored value OR mask. The masks are:
  - 0: 0x80, 1: 0x3F, 2: 0x00, 3: 0xFF, 4: 0xBF (pulse 1)
  - 5: 0x3F, 6: 0x00, 7: 0xFF, 8: 0xBF (pulse 2)
  - 9: 0x7F, 10: 0xFF, 11: 0x9F, 12: 0xFF, 13: 0xBF (wave)
  - 14: 0xFF, 15: 0x00, 16: 0x00, 17: 0xBF (noise)
  - 18: 0x00, 19: 0x00 (mixer)
- R3: The status register is at index 20. Only its bit 7 (power) is writable. Bits 6:4 always read 1, and bits 3:0 read the ch_active input.
- R4: In `PWR_OFF`, a write to any register at indices 0..19 leaves the stored value at 0 and raises no strobe, except as stated in R6 and R7.
- R5: A `POWER_DOWN` write clears indices 0..19 to 0 on the same clock edge that enters `PWR_OFF`.
- R6: With LEGACY_MODEL=1, the wave length register (10) and the noise length register (14) are stored and strobed even in `PWR_OFF`. With LEGACY_MODEL=0 they are not.
- R7: With LEGACY_MODEL=1, a write in `PWR_OFF` to the pulse duty/length registers (1, 5) raises their strobe with stb_data = wdata & 0x3F, and the stored value stays 0. With LEGACY_MODEL=0 there is no strobe.
- R8: An accepted write to index i (0..20) sets reg_stb to the one-hot value 1<<i for exactly the cycle after the write, with stb_data equal to the written byte. Writes to the waveform store or to unmapped addresses raise no strobe.
- R9: While the wave channel is not playing, addresses 0x20..0x2F read and write waveform byte (addr - 0x20). This does not depend on the power state.
- R10: While the wave channel is playing with LEGACY_MODEL=0, waveform reads return byte wave_pos>>1 and waveform writes go to the addressed byte.
- R11: While the wave channel is playing with LEGACY_MODEL=1, waveform reads and writes use byte wave_pos>>1 when wave_window is 1. When wave_window is 0, reads return 0xFF and writes are dropped.
- R12: Addresses 21..31 and 0x30..0x3F read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_addr | input | ADDR_W | Register or waveform address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ch_active | input | 4 | Per-channel active flags from the channel logic |
| wave_playing | input | 1 | Wave channel is running |
| wave_pos | input | log2(2*WAVE_BYTES) | Current wave sample index |
| wave_window | input | 1 | Wave channel access window (legacy build) |
| reg_stb | output | 21 | One-cycle per-register write strobes |
| stb_data | output | 8 | Value forwarded with the strobe |

## Verification
The bench builds two copies side by side, both driven by the same bus. One copy has LEGACY_MODEL=1 and the other LEGACY_MODEL=0, and both use the default 6-bit address and 16-byte waveform store. Running the copies together lets a single write sequence in `PWR_OFF` show both outcomes: the legacy copy's length exemption and duty forwarding, and the newer copy's silence. The same holds while the wave channel plays: the windowed or 0xFF behaviour of the legacy copy is set against the always-redirected reads and addressed writes of the newer copy.

// File: rtl/snd_regs_pkg.sv
package snd_regs_pkg;

    localparam int NCTRL   = 20;
    localparam int PWR_IDX = 20;
    localparam int NREG    = 21;

    localparam int P1_SWEEP = 0;
    localparam int P1_DUTY  = 1;
    localparam int P2_DUTY  = 5;
    localparam int W_LEN    = 10;
    localparam int N_LEN    = 14;
    localparam int M_VOL    = 18;
    localparam int M_ROUTE  = 19;

    localparam logic [7:0] VOL_RST   = 8'h77;
    localparam logic [7:0] ROUTE_RST = 8'hF3;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    function automatic logic [7:0] rd_mask(input int idx);
        case (idx)
            0:       return 8'h80;
            1, 5:    return 8'h3F;
            2, 6:    return 8'h00;
            3, 7:    return 8'hFF;
            4, 8:    return 8'hBF;
            9:       return 8'h7F;
            10, 12:  return 8'hFF;
            11:      return 8'h9F;
            13:      return 8'hBF;
            14:      return 8'hFF;
            15, 16:  return 8'h00;
            17:      return 8'hBF;
            18, 19:  return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic len_keep(input int idx);
        return (idx == W_LEN) || (idx == N_LEN);
    endfunction

    function automatic logic duty_reg(input int idx);
        return (idx == P1_DUTY) || (idx == P2_DUTY);
    endfunction

endpackage

// File: rtl/snd_power_fsm.sv
module snd_power_fsm
    import snd_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_wr,
    input  logic pwr_bit,
    output logic pwr_on,
    output logic clr_all
);

    pwr_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_ON;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PWR_ON:  if (pwr_wr && !pwr_bit) state_n = PWR_OFF;  // POWER_DOWN
            PWR_OFF: if (pwr_wr &&  pwr_bit) state_n = PWR_ON;   // POWER_UP
        endcase
    end

    always_comb begin
        pwr_on  = (state_q == PWR_ON);
        clr_all = (state_q == PWR_ON) && (state_n == PWR_OFF);
    end

    assert_power_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && !pwr_bit) |=> !pwr_on);

    assert_power_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && pwr_bit) |=> pwr_on);

endmodule

// File: rtl/snd_ctrl_regs.sv
module snd_ctrl_regs
    import snd_regs_pkg::*;
#(
    parameter bit LEGACY_MODEL = 1'b1,
    parameter int ADDR_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              pwr_on,
    input  logic              clr_all,
    output logic [7:0]        rd_val,
    output logic [NREG-1:0]   stb,
    output logic [7:0]        stb_data
);

    logic [NCTRL-1:0][7:0] q;

    for (genvar g = 0; g < NCTRL; g++) begin : g_reg
        localparam logic [7:0] RV = (g == M_VOL)   ? VOL_RST :
                                    (g == M_ROUTE) ? ROUTE_RST : 8'h00;
        localparam bit KEEP = LEGACY_MODEL && len_keep(g);
        logic [7:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= RV;
            else if (clr_all)
                r <= 8'h00;
            else if (wr_en && addr == ADDR_W'(g) && (pwr_on || KEEP))
                r <= wdata;
        end
        assign q[g] = r;
    end

    always_comb begin
        rd_val = 8'hFF;
        for (int i = 0; i < NCTRL; i++)
            if (addr == ADDR_W'(i)) rd_val = q[i] | rd_mask(i);
    end

    logic [NREG-1:0] stb_n;
    logic [7:0]      sd_n;

    always_comb begin
        stb_n = '0;
        sd_n  = wdata;
        if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (addr == ADDR_W'(i)) begin
                    if (i == PWR_IDX || pwr_on || (LEGACY_MODEL && len_keep(i))) begin
                        stb_n[i] = 1'b1;
                    end else if (LEGACY_MODEL && duty_reg(i)) begin
                        stb_n[i] = 1'b1;
                        sd_n     = wdata & 8'h3F;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb      <= '0;
            stb_data <= 8'h00;
        end else begin
            stb      <= stb_n;
            stb_data <= sd_n;
        end
    end

    logic [7:0] gated_or;
    always_comb begin
        gated_or = 8'h00;
        for (int i = 0; i < NCTRL; i++)
            if (!(LEGACY_MODEL && len_keep(i))) gated_or |= q[i];
    end

    assert_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (gated_or == 8'h00));

    assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    assert_stb_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(PWR_IDX)) |=> (stb[PWR_IDX] && stb_data == $past(wdata)));

endmodule

// File: rtl/snd_wave_ram.sv
module snd_wave_ram #(
    parameter bit LEGACY_MODEL = 1'b1,
    parameter int WAVE_BYTES   = 16,
    localparam int BW          = $clog2(WAVE_BYTES),
    localparam int PW          = $clog2(2 * WAVE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] byte_addr,
    input  logic [7:0]    wdata,
    input  logic          playing,
    input  logic [PW-1:0] pos,
    input  logic          window,
    output logic [7:0]    rdata
);

    logic [7:0] mem [WAVE_BYTES];
    logic [BW-1:0] cur;
    logic [BW-1:0] wr_idx;
    logic          wr_ok;

    assign cur = BW'(pos >> 1);

    always_comb begin
        if (!playing || !LEGACY_MODEL) begin
            wr_idx = byte_addr;
            wr_ok  = wr_en;
        end else begin
            wr_idx = cur;
            wr_ok  = wr_en && window;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAVE_BYTES; i++) mem[i] <= 8'h00;
        end else if (wr_ok) begin
            mem[wr_idx] <= wdata;
        end
    end

    always_comb begin
        if (!playing)                     rdata = mem[byte_addr];
        else if (window || !LEGACY_MODEL) rdata = mem[cur];
        else                              rdata = 8'hFF;
    end

    logic [8*WAVE_BYTES-1:0] mem_flat;
    always_comb
        for (int i = 0; i < WAVE_BYTES; i++) mem_flat[8*i +: 8] = mem[i];

    assert_blind_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (LEGACY_MODEL && playing && !window) |=> $stable(mem_flat));

    assert_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !playing) |=> (mem[$past(byte_addr)] == $past(wdata)));

endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank
    import snd_regs_pkg::*;
#(
    parameter bit LEGACY_MODEL = 1'b1,
    parameter int ADDR_W       = 6,
    parameter int WAVE_BASE    = 32,
    parameter int WAVE_BYTES   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [7:0]                        bus_wdata,
    output logic [7:0]                        bus_rdata,
    input  logic [3:0]                        ch_active,
    input  logic                              wave_playing,
    input  logic [$clog2(2*WAVE_BYTES)-1:0]   wave_pos,
    input  logic                              wave_window,
    output logic [NREG-1:0]                   reg_stb,
    output logic [7:0]                        stb_data
);

    localparam int BW = $clog2(WAVE_BYTES);

    logic pwr_on, clr_all, pwr_wr, wave_hit;
    logic [BW-1:0] wave_off;
    logic [7:0] ctrl_rd, wave_rd;

    assign pwr_wr   = bus_wr && (bus_addr == ADDR_W'(PWR_IDX));
    assign wave_hit = (int'(bus_addr) >= WAVE_BASE) && (int'(bus_addr) < WAVE_BASE + WAVE_BYTES);
    assign wave_off = BW'(bus_addr - ADDR_W'(WAVE_BASE));

    snd_power_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_wr  (pwr_wr),
        .pwr_bit (bus_wdata[7]),
        .pwr_on  (pwr_on),
        .clr_all (clr_all)
    );

    snd_ctrl_regs #(.LEGACY_MODEL(LEGACY_MODEL), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pwr_on   (pwr_on),
        .clr_all  (clr_all),
        .rd_val   (ctrl_rd),
        .stb      (reg_stb),
        .stb_data (stb_data)
    );

    snd_wave_ram #(.LEGACY_MODEL(LEGACY_MODEL), .WAVE_BYTES(WAVE_BYTES)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && wave_hit),
        .byte_addr (wave_off),
        .wdata     (bus_wdata),
        .playing   (wave_playing),
        .pos       (wave_pos),
        .window    (wave_window),
        .rdata     (wave_rd)
    );

    always_comb begin
        if (wave_hit)                                bus_rdata = wave_rd;
        else if (bus_addr == ADDR_W'(PWR_IDX))       bus_rdata = {pwr_on, 3'b111, ch_active};
        else                                         bus_rdata = ctrl_rd;
    end

    assert_wave_no_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wave_hit) |=> (reg_stb == '0));

endmodule

// File: tb/snd_reg_bank_test.sv
module snd_reg_bank_test;
    import snd_regs_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [3:0] ch_active = 4'b0001;
    logic wave_playing = 1'b0;
    logic [4:0] wave_pos = '0;
    logic wave_window = 1'b0;
    logic [7:0] rd_l, rd_n, sd_l, sd_n;
    logic [NREG-1:0] stb_l, stb_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    snd_reg_bank #(.LEGACY_MODEL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .ch_active(ch_active),
        .wave_playing(wave_playing), .wave_pos(wave_pos), .wave_window(wave_window),
        .reg_stb(stb_l), .stb_data(sd_l));

    snd_reg_bank #(.LEGACY_MODEL(1'b0)) uut_nw (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_n), .ch_active(ch_active),
        .wave_playing(wave_playing), .wave_pos(wave_pos), .wave_window(wave_window),
        .reg_stb(stb_n), .stb_data(sd_n));

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [7:0] r;
    } vec_t;

    // write, read back, expected OR-masked value, requirement number (R2, R8, R12)
    localparam vec_t VECS [15] = '{
        '{8'd0,  8'h12, 8'h92, 8'd2},
        '{8'd1,  8'hC5, 8'hFF, 8'd2},
        '{8'd2,  8'hA5, 8'hA5, 8'd2},
        '{8'd3,  8'h00, 8'hFF, 8'd2},
        '{8'd4,  8'h07, 8'hBF, 8'd2},
        '{8'd5,  8'h01, 8'h3F, 8'd2},
        '{8'd6,  8'hC3, 8'hC3, 8'd2},
        '{8'd9,  8'h00, 8'h7F, 8'd2},
        '{8'd11, 8'h20, 8'hBF, 8'd2},
        '{8'd15, 8'h5A, 8'h5A, 8'd2},
        '{8'd16, 8'h3C, 8'h3C, 8'd2},
        '{8'd17, 8'h40, 8'hFF, 8'd2},
        '{8'd18, 8'h12, 8'h12, 8'd2},
        '{8'd19, 8'h81, 8'h81, 8'd2},
        '{8'd21, 8'h33, 8'hFF, 8'd12}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(6'd20); chk("R1 status", rd_l, 8'hF1); chk("R1 status nw", rd_n, 8'hF1);
        rd(6'd18); chk("R1 volume", rd_l, 8'h77);
        rd(6'd19); chk("R1 routing", rd_l, 8'hF3);
        rd(6'd4);  chk("R1 ch reg", rd_l, 8'hBF);

        for (int i = 0; i < 15; i++) begin
            wr(VECS[i].a[5:0], VECS[i].d);
            chk($sformatf("R8 strobe idx %0d", VECS[i].a), stb_l,
                (VECS[i].a < 8'd21) ? (NREG'(1) << VECS[i].a) : NREG'(0));
            if (VECS[i].a < 8'd21) chk("R8 stb data", sd_l, VECS[i].d);
            rd(VECS[i].a[5:0]);
            chk($sformatf("R%0d readback idx %0d", VECS[i].r, VECS[i].a), rd_l, VECS[i].e);
        end
        rd(6'h3A); chk("R12 high unmapped", rd_l, 8'hFF);

        // R3 status: only bit 7 writable
        ch_active = 4'b0101;
        wr(6'd20, 8'hFF); chk("R8 status strobe", stb_l, NREG'(1) << 20);
        rd(6'd20); chk("R3 status", rd_l, 8'hF5);

        // R5 power down clears
        wr(6'd20, 8'h00);
        rd(6'd20); chk("R3 power off read", rd_l, 8'h75);
        rd(6'd2);  chk("R5 cleared 2", rd_l, 8'h00);
        rd(6'd18); chk("R5 cleared vol", rd_l, 8'h00);
        rd(6'd6);  chk("R5 cleared 6", rd_l, 8'h00);
        rd(6'd0);  chk("R5 cleared 0", rd_l, 8'h80);

        // R4 writes dropped while off
        wr(6'd2, 8'h55); chk("R4 no strobe", stb_l, NREG'(0));
        rd(6'd2); chk("R4 dropped", rd_l, 8'h00); chk("R4 dropped nw", rd_n, 8'h00);

        // R6 length exemption
        wr(6'd10, 8'h42);
        chk("R6 legacy len strobe", stb_l, NREG'(1) << 10);
        chk("R6 legacy len data", sd_l, 8'h42);
        chk("R6 newer no strobe", stb_n, NREG'(0));
        wr(6'd14, 8'h09);
        chk("R6 noise len strobe", stb_l, NREG'(1) << 14);

        // R7 duty pass-through
        wr(6'd1, 8'hC7);
        chk("R7 duty strobe", stb_l, NREG'(1) << 1);
        chk("R7 duty data", sd_l, 8'h07);
        chk("R7 newer no strobe", stb_n, NREG'(0));
        rd(6'd1); chk("R7 not stored", rd_l, 8'h3F);

        // power up
        wr(6'd20, 8'h80);
        rd(6'd20); chk("R3 power on", rd_l, 8'hF5);
        wr(6'd2, 8'h33); rd(6'd2); chk("R4 accepted again", rd_l, 8'h33);

        // R9 idle wave access
        wr(6'h25, 8'hAB); chk("R8 wave no strobe", stb_l, NREG'(0));
        rd(6'h25); chk("R9 wave read", rd_l, 8'hAB); chk("R9 wave read nw", rd_n, 8'hAB);
        rd(6'h24); chk("R9 wave other", rd_l, 8'h00);

        // R10 / R11 playing
        @(negedge clk); wave_playing = 1'b1; wave_pos = 5'd10; wave_window = 1'b0;
        rd(6'h20); chk("R11 blind read", rd_l, 8'hFF); chk("R10 redirected read", rd_n, 8'hAB);
        wr(6'h21, 8'h11);
        wr(6'h22, 8'h66);
        @(negedge clk); wave_window = 1'b1;
        rd(6'h2F); chk("R11 window read", rd_l, 8'hAB);
        wr(6'h20, 8'h99);
        rd(6'h20); chk("R11 window write", rd_l, 8'h99); chk("R10 pos read", rd_n, 8'hAB);
        @(negedge clk); wave_playing = 1'b0; wave_window = 1'b0;
        rd(6'h21); chk("R11 dropped", rd_l, 8'h00); chk("R10 addressed write", rd_n, 8'h11);
        rd(6'h25); chk("R11 pos byte", rd_l, 8'h99); chk("R10 pos byte kept", rd_n, 8'hAB);
        rd(6'h20); chk("R11 byte0 kept", rd_l, 8'h00); chk("R10 byte0", rd_n, 8'h99);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule